// File: doc/BRIEF.md
# Multiword DMA Handshake Engine

This block is the host-side sequencer for burst DMA on a 16-bit parallel disk interface. Once software or a higher-level controller arms it with a direction, a timing mode (0, 1 or 2) and a word count, the engine watches the device's request line. When the request is seen, it drives an active-low acknowledge. While acknowledge is held, it issues a train of read or write strobes. Every strobe keeps the minimum pulse width, cycle time, data setup and data hold of the selected mode. All timing figures in nanoseconds are converted to clock counts by ceiling division on the clock period parameter.

Write data comes from a valid/ready word stream. A word is taken at the start of each write strobe and is driven onto the bus from that point until the hold time after the strobe rises. Read data is captured at the clock edge that raises the read strobe and is presented on a one-cycle valid output.

The device may pause a burst by dropping its request. After acknowledge rises or a strobe ends, the engine gives the request line a mode-dependent settling window. It then distinguishes a pause, where acknowledge is released and the remaining count is kept, from completion, where the count reaches zero, acknowledge is released and the done flag is raised.

Top module: `dmah_engine`

## Requirements
- R1: During reset and right after it: acknowledge, read strobe and write strobe are all high (negated), the bus is not driven, done is 0 and the remaining count is 0.
- R2: Acknowledge goes low only when a transfer is armed and the request input was sampled high at the preceding clock edge. While the request is low, an armed engine keeps acknowledge high.
- R3: A strobe goes low only while acknowledge is low. Reads use only the read strobe and writes use only the write strobe. The two strobes are never low together.
- R4: Each strobe stays low for exactly S clocks. S = max(ceil(pulse/T), ceil(setup/T)), where T is the clock period. Pulse is 480/240/120 ns for modes 0/1/2. Setup is 250/150/50 ns for reads and 250/100/35 ns for writes. A mode value of 3 behaves as mode 2.
- R5: Within one burst, the strobe stays high between two strobes for at least ceil(cycle/T) − S clocks, where cycle is 960/480/240 ns.
- R6: A read word is captured from the bus at the edge that raises the read strobe. It appears on rd_data with rd_valid high for that one cycle. Words come out in strobe order.
- R7: On writes, one source word is consumed per strobe (src_ready high for one cycle while src_valid is high). That word is driven with dd_oe high from the strobe's fall until exactly ceil(hold/T) clocks after its rise, with hold 50/30/20 ns. On reads, dd_oe stays low.
- R8: After the last word, acknowledge returns high, done reads 1 and words_left reads 0. Exactly the programmed number of strobes has been issued.
- R9: If the request is low once the settling window of ceil(200/100/80 ns / T) clocks after a strobe has expired, acknowledge is released. This happens within recovery + window + 3 clocks. words_left holds the words not yet moved, done stays 0, and no strobe is issued until the request returns, after which the burst resumes.
- R10: start is ignored while a transfer is armed or running. A start with a word count of 0 sets done at once and never asserts acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm a transfer (taken only when idle) |
| xfer_write | input | 1 | 1 = write to device, 0 = read from device |
| xfer_mode | input | 2 | Timing mode 0..2 (3 acts as 2) |
| xfer_words | input | CNT_W | Number of words to move |
| dmarq | input | 1 | Device request, active high |
| dmack_n | output | 1 | Acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_in | input | DW | Bus value seen from the device |
| dd_out | output | DW | Bus value driven by the host |
| dd_oe | output | 1 | Host drives the bus when high |
| src_valid | input | 1 | Write source has a word |
| src_data | input | DW | Write source word |
| src_ready | output | 1 | Write word taken this cycle |
| rd_valid | output | 1 | Read word valid this cycle |
| rd_data | output | DW | Read word |
| done | output | 1 | Last transfer completed |
| words_left | output | CNT_W | Words not yet transferred |

## Verification
All bus outputs are registered. Acknowledge falls one clock after the armed engine samples the request high. A strobe falls on the clock after the engine decides to launch it, stays low for S clocks and rises on the same edge that makes rd_valid high. The write bus stays driven for the hold count after that edge. The bench samples every output on the falling clock edge, half a period after the register that sets it. It measures strobe widths, gaps and hold lengths as counts of those samples, so every figure is compared in whole clocks against the ceiling-divided value. Pause release is measured from the sample where the model drops its request, and the bound allows for the recovery, the window and one cycle of sampling skew.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_GAP,
        ST_STRB,
        ST_RECOV
    } dmah_st_e;

    localparam int NUM_MODES = 3;

    function automatic int clk_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cycle_ns(input int m);
        case (m)
            0:       return 960;
            1:       return 480;
            default: return 240;
        endcase
    endfunction

    function automatic int pulse_ns(input int m);
        case (m)
            0:       return 480;
            1:       return 240;
            default: return 120;
        endcase
    endfunction

    function automatic int rd_setup_ns(input int m);
        case (m)
            0:       return 250;
            1:       return 150;
            default: return 50;
        endcase
    endfunction

    function automatic int wr_setup_ns(input int m);
        case (m)
            0:       return 250;
            1:       return 100;
            default: return 35;
        endcase
    endfunction

    function automatic int wr_hold_ns(input int m);
        case (m)
            0:       return 50;
            1:       return 30;
            default: return 20;
        endcase
    endfunction

    function automatic int req_drop_ns(input int m);
        case (m)
            0:       return 200;
            1:       return 100;
            default: return 80;
        endcase
    endfunction

endpackage

// File: rtl/dmah_timing.sv
module dmah_timing
    import dmah_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int TW     = 8
) (
    input  logic [1:0]    mode,
    input  logic          wr,
    output logic [TW-1:0] strb_cyc,
    output logic [TW-1:0] rec_cyc,
    output logic [TW-1:0] hold_cyc,
    output logic [TW-1:0] win_cyc
);

    logic [TW-1:0] strb_t [NUM_MODES][2];
    logic [TW-1:0] rec_t  [NUM_MODES][2];
    logic [TW-1:0] hold_t [NUM_MODES];
    logic [TW-1:0] win_t  [NUM_MODES];
    logic [1:0]    sel;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam int HOLD = clk_ceil(wr_hold_ns(m), CLK_NS);
        localparam int WIN  = imax(clk_ceil(req_drop_ns(m), CLK_NS), 1);
        assign hold_t[m] = TW'(HOLD);
        assign win_t[m]  = TW'(WIN);
        for (genvar d = 0; d < 2; d++) begin : g_dir
            localparam int SETUP = clk_ceil((d == 1) ? wr_setup_ns(m) : rd_setup_ns(m), CLK_NS);
            localparam int STRB  = imax(imax(clk_ceil(pulse_ns(m), CLK_NS), SETUP), 1);
            localparam int REC   = imax(imax(clk_ceil(cycle_ns(m), CLK_NS) - STRB, HOLD), 1);
            assign strb_t[m][d] = TW'(STRB);
            assign rec_t[m][d]  = TW'(REC);
        end
    end

    // mode 3 is folded onto the fastest mode
    assign sel      = (mode >= 2'd2) ? 2'd2 : mode;
    assign strb_cyc = strb_t[sel][wr];
    assign rec_cyc  = rec_t[sel][wr];
    assign hold_cyc = hold_t[sel];
    assign win_cyc  = win_t[sel];

endmodule

// File: rtl/dmah_tick.sv
module dmah_tick #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R4
    tick_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/dmah_engine.sv
module dmah_engine
    import dmah_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int DW     = 16,
    parameter int CNT_W  = 16,
    parameter int TW     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             xfer_write,
    input  logic [1:0]       xfer_mode,
    input  logic [CNT_W-1:0] xfer_words,
    input  logic             dmarq,
    output logic             dmack_n,
    output logic             dior_n,
    output logic             diow_n,
    input  logic [DW-1:0]    dd_in,
    output logic [DW-1:0]    dd_out,
    output logic             dd_oe,
    input  logic             src_valid,
    input  logic [DW-1:0]    src_data,
    output logic             src_ready,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic [CNT_W-1:0] words_left
);

    typedef struct packed {
        dmah_st_e         st;
        logic             ack_n;
        logic             rd_n;
        logic             wr_n;
        logic             oe;
        logic             rvalid;
        logic             done;
        logic             wr;
        logic [1:0]       mode;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, ack_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0,
        rvalid: 1'b0, done: 1'b0, wr: 1'b0, mode: 2'd0,
        wdata: '0, rdata: '0, cnt: '0
    };

    regs_t r_d, r_q;

    logic [TW-1:0] strb_cyc, rec_cyc, hold_cyc, win_cyc;
    logic [TW-1:0] phase_cnt, win_cnt, hold_cnt;
    logic [TW-1:0] phase_val;
    logic          phase_ld, win_ld, hold_ld;
    logic          take_word;

    dmah_timing #(.CLK_NS(CLK_NS), .TW(TW)) u_timing (
        .mode     (r_q.mode),
        .wr       (r_q.wr),
        .strb_cyc (strb_cyc),
        .rec_cyc  (rec_cyc),
        .hold_cyc (hold_cyc),
        .win_cyc  (win_cyc)
    );

    dmah_tick #(.TW(TW)) u_phase (
        .clk (clk), .rst_n (rst_n), .load (phase_ld), .load_val (phase_val), .cnt (phase_cnt)
    );

    dmah_tick #(.TW(TW)) u_window (
        .clk (clk), .rst_n (rst_n), .load (win_ld), .load_val (win_cyc), .cnt (win_cnt)
    );

    dmah_tick #(.TW(TW)) u_hold (
        .clk (clk), .rst_n (rst_n), .load (hold_ld), .load_val (hold_cyc), .cnt (hold_cnt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rvalid = 1'b0;
        phase_ld  = 1'b0;
        phase_val = '0;
        win_ld    = 1'b0;
        hold_ld   = 1'b0;
        take_word = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.wr   = xfer_write;
                    r_d.mode = xfer_mode;
                    r_d.cnt  = xfer_words;
                    r_d.done = (xfer_words == '0);
                    r_d.st   = (xfer_words == '0) ? ST_IDLE : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (dmarq) begin
                    r_d.ack_n = 1'b0;
                    r_d.st    = ST_GAP;
                    win_ld    = 1'b1;
                end
            end
            ST_GAP: begin
                if (r_q.cnt == '0) begin
                    r_d.ack_n = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end else if (dmarq && (!r_q.wr || src_valid)) begin
                    r_d.st    = ST_STRB;
                    phase_ld  = 1'b1;
                    phase_val = strb_cyc - TW'(1);
                    if (r_q.wr) begin
                        r_d.wr_n  = 1'b0;
                        r_d.oe    = 1'b1;
                        r_d.wdata = src_data;
                        take_word = 1'b1;
                    end else begin
                        r_d.rd_n = 1'b0;
                    end
                end else if (!dmarq && win_cnt == '0) begin
                    r_d.ack_n = 1'b1;
                    r_d.st    = ST_ARMED;
                end
            end
            ST_STRB: begin
                if (phase_cnt == '0) begin
                    r_d.rd_n  = 1'b1;
                    r_d.wr_n  = 1'b1;
                    r_d.st    = ST_RECOV;
                    phase_ld  = 1'b1;
                    phase_val = rec_cyc - TW'(1);
                    win_ld    = 1'b1;
                    hold_ld   = 1'b1;
                    r_d.cnt   = r_q.cnt - CNT_W'(1);
                    r_d.oe    = r_q.wr && (hold_cyc != '0);
                    if (!r_q.wr) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = dd_in;
                    end
                end
            end
            ST_RECOV: begin
                r_d.oe = r_q.oe && (hold_cnt > TW'(1));
                if (phase_cnt == '0) begin
                    r_d.st = ST_GAP;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign dmack_n    = r_q.ack_n;
    assign dior_n     = r_q.rd_n;
    assign diow_n     = r_q.wr_n;
    assign dd_out     = r_q.wdata;
    assign dd_oe      = r_q.oe;
    assign src_ready  = take_word;
    assign rd_valid   = r_q.rvalid;
    assign rd_data    = r_q.rdata;
    assign done       = r_q.done;
    assign words_left = r_q.cnt;

    // R3
    strobe_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.rd_n || !r_q.wr_n) |-> !r_q.ack_n);

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rd_n || r_q.wr_n));

    // R2
    ack_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ack_n) |-> $past(dmarq));

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.wr_n |-> r_q.oe);

    // R6
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rvalid |-> (r_q.rd_n && $past(!r_q.rd_n)));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.ack_n && r_q.cnt == '0));

endmodule

// File: tb/test_dmah_engine.sv
module test_dmah_engine;

    localparam int CLK_NS  = 20;
    localparam int DW      = 16;
    localparam int CNT_W   = 16;
    localparam int WD_MAX  = 150000;
    localparam logic [15:0] RD_BASE = 16'hA500;
    localparam logic [15:0] WR_BASE = 16'h3C00;

    // {mode[14:13], write[12], words[11:6], pause_after[5:0]}
    localparam int NVEC = 8;
    localparam logic [14:0] VECS [NVEC] = '{
        {2'd0, 1'b0, 6'd2, 6'd0},
        {2'd0, 1'b1, 6'd2, 6'd0},
        {2'd1, 1'b0, 6'd3, 6'd0},
        {2'd1, 1'b1, 6'd3, 6'd0},
        {2'd2, 1'b0, 6'd4, 6'd0},
        {2'd3, 1'b1, 6'd3, 6'd0},
        {2'd2, 1'b1, 6'd4, 6'd2},
        {2'd1, 1'b0, 6'd5, 6'd3}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             xfer_write = 1'b0;
    logic [1:0]       xfer_mode = 2'd0;
    logic [CNT_W-1:0] xfer_words = '0;
    logic             dmarq;
    logic             dmack_n, dior_n, diow_n, dd_oe, src_ready, rd_valid, done;
    logic [DW-1:0]    dd_in = '0;
    logic [DW-1:0]    dd_out, rd_data, src_data;
    logic             src_valid = 1'b1;
    logic [CNT_W-1:0] words_left;

    // bench control (written by the main sequence)
    logic clr_mon = 1'b1;
    logic dev_on  = 1'b0;
    logic resume  = 1'b0;
    logic cur_wr  = 1'b0;
    int   pause_at = 0;
    int   e_strb = 1, e_gap = 0, e_hold = 0, e_rec = 1, e_win = 1;
    int   n_chk = 0, n_bad = 0;

    // monitor state (written by the monitor only)
    logic drop_req = 1'b0;
    logic pend = 1'b0, p_rd = 1'b1, p_wr = 1'b1, hold_on = 1'b0;
    int   stb_count = 0, rd_idx = 0, widx = 0;
    int   low_len = 0, high_len = 0, hold_cnt = 0;
    int   mon_chk = 0, mon_bad = 0;
    int   cyc = 0;

    assign dmarq    = dev_on && (!drop_req || resume);
    assign src_data = WR_BASE + 16'(widx);

    always #(CLK_NS / 2) clk = ~clk;

    dmah_engine #(.CLK_NS(CLK_NS), .DW(DW), .CNT_W(CNT_W), .TW(8)) i_dmah_engine (
        .clk (clk), .rst_n (rst_n), .start (start), .xfer_write (xfer_write),
        .xfer_mode (xfer_mode), .xfer_words (xfer_words), .dmarq (dmarq),
        .dmack_n (dmack_n), .dior_n (dior_n), .diow_n (diow_n), .dd_in (dd_in),
        .dd_out (dd_out), .dd_oe (dd_oe), .src_valid (src_valid), .src_data (src_data),
        .src_ready (src_ready), .rd_valid (rd_valid), .rd_data (rd_data),
        .done (done), .words_left (words_left)
    );

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    function automatic int ns_of(input int kind, input int m);
        int mm;
        mm = (m > 2) ? 2 : m;
        case (kind)
            0: return (mm == 0) ? 480 : (mm == 1) ? 240 : 120;   // pulse
            1: return (mm == 0) ? 250 : (mm == 1) ? 150 : 50;    // read setup
            2: return (mm == 0) ? 250 : (mm == 1) ? 100 : 35;    // write setup
            3: return (mm == 0) ? 50  : (mm == 1) ? 30  : 20;    // write hold
            4: return (mm == 0) ? 960 : (mm == 1) ? 480 : 240;   // cycle
            default: return (mm == 0) ? 200 : (mm == 1) ? 100 : 80; // request settle
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic mchk(input bit ok, input string tag, input int act, input int exp);
        mon_chk++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk, n_bad + mon_bad);
        $finish;
    endtask

    // bus model and timing monitor, sampled on the falling edge
    always @(negedge clk) begin
        logic s_n, ps, other_n;
        if (clr_mon) begin
            stb_count = 0; rd_idx = 0; widx = 0; pend = 1'b0; drop_req = 1'b0;
            low_len = 0; high_len = 0; hold_cnt = 0; hold_on = 1'b0;
            p_rd = 1'b1; p_wr = 1'b1;
        end else if (rst_n) begin
            if (pend) begin widx++; pend = 1'b0; end
            if (src_ready) pend = 1'b1;
            s_n     = cur_wr ? diow_n : dior_n;
            ps      = cur_wr ? p_wr : p_rd;
            other_n = cur_wr ? dior_n : diow_n;
            if (!other_n) mchk(1'b0, "R3 wrong strobe line", 0, 1);
            if (ps && !s_n) begin
                mchk(!dmack_n, "R3 strobe without ack", dmack_n, 0);
                if (stb_count > 0) mchk(high_len >= e_gap, "R5 gap", high_len, e_gap);
                if (cur_wr) mchk(dd_oe == 1'b1, "R7 drive at strobe fall", dd_oe, 1);
                else begin
                    mchk(dd_oe == 1'b0, "R7 no drive on read", dd_oe, 0);
                    dd_in = RD_BASE + 16'(stb_count);
                end
                low_len = 1;
            end else if (!s_n) begin
                low_len++;
            end else if (!ps && s_n) begin
                mchk(low_len == e_strb, "R4 strobe width", low_len, e_strb);
                if (cur_wr) begin
                    mchk(dd_oe && dd_out == WR_BASE + 16'(stb_count), "R7 write word",
                         dd_out, WR_BASE + 16'(stb_count));
                    hold_cnt = 1; hold_on = 1'b1;
                end
                stb_count++;
                high_len = 1;
                if (pause_at != 0 && stb_count == pause_at) drop_req = 1'b1;
            end else begin
                high_len++;
                if (hold_on) begin
                    if (dd_oe) hold_cnt++;
                    else begin
                        mchk(hold_cnt == e_hold, "R7 hold length", hold_cnt, e_hold);
                        hold_on = 1'b0;
                    end
                end
            end
            if (rd_valid) begin
                mchk(rd_data == RD_BASE + 16'(rd_idx), "R6 read word", rd_data, RD_BASE + 16'(rd_idx));
                rd_idx++;
            end
            p_rd = dior_n; p_wr = diow_n;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_MAX);
            summary();
        end
    end

    task automatic set_expect(input int m, input bit w);
        int su;
        su     = cdiv(ns_of(w ? 2 : 1, m));
        e_strb = (cdiv(ns_of(0, m)) > su) ? cdiv(ns_of(0, m)) : su;
        e_gap  = cdiv(ns_of(4, m)) - e_strb;
        e_hold = cdiv(ns_of(3, m));
        e_rec  = (e_gap > e_hold) ? e_gap : e_hold;
        e_win  = cdiv(ns_of(5, m));
    endtask

    task automatic clear_monitor();
        clr_mon = 1'b1;
        repeat (2) @(negedge clk);
        clr_mon = 1'b0;
    endtask

    task automatic run_xfer(input int m, input bit w, input int words, input int pause, input bit poke);
        int n;
        cur_wr = w; pause_at = pause; dev_on = 1'b0; resume = 1'b0;
        set_expect(m, w);
        clear_monitor();
        xfer_mode = 2'(m); xfer_write = w; xfer_words = CNT_W'(words);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        // R2: armed but no request -> no acknowledge
        chk(dmack_n == 1'b1 && done == 1'b0, "R2 ack held off", dmack_n, 1);
        dev_on = 1'b1;
        if (poke) begin
            n = 0;
            while (dmack_n && n < 100) begin @(negedge clk); n++; end
            xfer_words = CNT_W'(9); xfer_write = ~w;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (pause != 0) begin
            n = 0;
            while (!drop_req && n < 20000) begin @(negedge clk); n++; end
            n = 0;
            while (!dmack_n && n < 2000) begin @(negedge clk); n++; end
            chk(n <= e_rec + e_win + 3, "R9 release delay", n, e_rec + e_win + 3);
            chk(done == 1'b0 && words_left == CNT_W'(words - pause), "R9 count kept",
                words_left, words - pause);
            repeat (8) @(negedge clk);
            chk(dmack_n == 1'b1 && stb_count == pause, "R9 quiet while paused", stb_count, pause);
            resume = 1'b1;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
        chk(done == 1'b1 && words_left == '0, "R8 done and count", words_left, 0);
        chk(dmack_n == 1'b1, "R8 ack released", dmack_n, 1);
        chk(stb_count == words, "R8 strobe count", stb_count, words);
        if (w) chk(widx == words, "R7 words consumed", widx, words);
        else   chk(rd_idx == words, "R6 words delivered", rd_idx, words);
        dev_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dmack_n && dior_n && diow_n, "R1 lines negated in reset", {dmack_n, dior_n, diow_n}, 7);
        chk(!dd_oe && !done && words_left == '0, "R1 bus and status in reset", {dd_oe, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dmack_n && dior_n && diow_n && !dd_oe, "R1 idle after reset", dmack_n, 1);

        for (int i = 0; i < NVEC; i++) begin
            run_xfer(int'(VECS[i][14:13]), VECS[i][12], int'(VECS[i][11:6]), int'(VECS[i][5:0]), 1'b0);
        end

        // R10: start while busy is ignored
        run_xfer(2, 1'b0, 3, 0, 1'b1);

        // R10: zero-length transfer
        cur_wr = 1'b0; pause_at = 0; set_expect(2, 1'b0);
        clear_monitor();
        dev_on = 1'b1;
        xfer_words = '0; xfer_mode = 2'd2; xfer_write = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(done == 1'b1 && dmack_n == 1'b1, "R10 zero count", {done, dmack_n}, 3);
        chk(stb_count == 0, "R10 no strobe", stb_count, 0);
        dev_on = 1'b0;

        // R1: reset in the middle of a strobe
        cur_wr = 1'b0; set_expect(0, 1'b0);
        clear_monitor();
        xfer_words = CNT_W'(4); xfer_mode = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dev_on = 1'b1;
        for (int k = 0; k < 100 && dior_n; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        clr_mon = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(dmack_n && dior_n && diow_n && !dd_oe, "R1 async reset mid-strobe", {dmack_n, dior_n}, 3);
        chk(!done && words_left == '0, "R1 status cleared", words_left, 0);
        dev_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        clr_mon = 1'b0;
        repeat (3) @(negedge clk);
        chk(dmack_n == 1'b1, "R1 stays idle after reset", dmack_n, 1);

        summary();
    end

endmodule